// File: doc/BRIEF.md
# Mixed-Trigger Interrupt Source Controller

This block holds the per-source state for a small array of interrupt inputs and turns their activity into presentations sent to a presentation controller, one at a time. Each source is set up as either message-triggered, which reacts to rising edges, or level-triggered, which follows the input's held value. Each source also stores a destination server number and an 8-bit priority. Every presentation is a (server, global number, priority) tuple, offered on a valid/ready handshake.

The presentation side controls the sources with three commands. Reject tells a source that its presentation was refused. End-of-interrupt tells a source that servicing is complete. Resend asks every source to offer again anything it still owes. Configuration writes change a source's server and priority, and a priority of all ones masks the source. Each level source keeps an asserted flag and a sent flag. Because of these, a level interrupt that is still held after a reject or an end-of-interrupt is offered again on the next resend and is not lost.

Sources are addressed by global number. A source's local index is its global number minus the parameter `BASE`.

The resend walk is a three-state machine:
- `SCAN_IDLE`: no walk is running. A resend command moves it to `SCAN_APPLY` at index 0.
- `SCAN_APPLY`: the resend rule is applied to the current index. It always moves on to `SCAN_HOLD`.
- `SCAN_HOLD`: it waits while the current source owes a presentation. Once the source is free, it either steps to the next index in `SCAN_APPLY` or, after the last index, returns to `SCAN_IDLE`.

A resend command in any state restarts the walk at index 0.

Top module: `isc_mixed_src_ctrl`

## Requirements
- R1: A source whose priority is 0xFF (all ones) is masked. `pres_prio` is never 0xFF while `pres_valid` is high, and a masked source never becomes owed.
- R2: Every request carries a global number. A number outside BASE to BASE+NUM_SRC-1 is ignored. This holds even when its low bits alias a valid index. `pres_num` equals BASE plus the local index.
- R3: After reset, every priority is 0xFF, every flag is clear, every source is message type, and `pres_valid` is low.
- R4: A rising input on an unmasked message source makes that source owe a presentation. On a masked message source, a rising input sets a pending-while-masked flag instead.
- R5: The asserted flag of a level source is its sampled input. On a rising input, the source is presented if it is not sent and not masked, and the sent flag is then set. While the sent flag is set, the source is not presented again.
- R6: For either type, a reject sets the rejected flag and clears the sent flag. A reject presents nothing by itself.
- R7: An end-of-interrupt clears the sent flag of a level source and presents nothing. On a message source it changes no state.
- R8: A resend walks every source. A level source is presented if it is asserted, not sent and unmasked, and its sent flag is then set. A rejected message source has its rejected flag cleared and is presented unless masked.
- R9: A configuration write first sets the server and priority. A level source then applies the rule from R8. A message source with the pending-while-masked flag set and an unmasked new priority clears that flag and is presented.
- R10: At most one presentation completes per cycle, and the lowest-index owed source is the one shown. An offer stays up until `pres_ready` is high. The resend walk visits indices in ascending order and holds on a source until that source's presentation is taken.
- R11: A configuration write of 0xFF to a source that owes a presentation withdraws the offer. A message source then becomes pending-while-masked. A level source has its sent flag cleared.
- R12: When a command and an input change hit the same source in the same cycle, the command is applied first and the input change is evaluated after it.
- R13: Writing to the type-assignment port with `asg_level` high sets a source to level type, and writing with it low sets message type. An out-of-range number is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_line | input | NUM_SRC | Interrupt input lines; bit i is local source i |
| asg_valid | input | 1 | Type assignment strobe |
| asg_num | input | NUM_W | Global number for the type assignment |
| asg_level | input | 1 | 1 = level type, 0 = message type |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_num | input | NUM_W | Global number for the configuration write |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority; all ones masks the source |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 = reject, 1 = end-of-interrupt, 2 = resend, 3 = no operation |
| cmd_num | input | NUM_W | Global number for reject and end-of-interrupt; unused for resend |
| pres_valid | output | 1 | A presentation is offered |
| pres_ready | input | 1 | The presentation controller takes the offer |
| pres_server | output | SRV_W | Server of the offered source |
| pres_num | output | NUM_W | Global number of the offered source |
| pres_prio | output | PRIO_W | Priority of the offered source |

## Verification
Two situations are hard to reach from the ports. One is a level source that is still held high after its sent flag has been cleared. This is only visible through the next resend, so the stimulus first has a level source presented, then clears its sent flag with a reject or an end-of-interrupt, and checks that nothing appears until a resend is issued. The other is the same-cycle ordering rule. To test it, the bench takes a presented level line low, which leaves the sent flag set. In a single cycle it then issues a reject and raises the line again. The source is presented only if the reject is applied before the input edge is evaluated.

// File: rtl/isc_pkg.sv
package isc_pkg;

    // Command codes accepted on cmd_op
    typedef enum logic [1:0] {
        CMD_REJECT = 2'd0,
        CMD_EOI    = 2'd1,
        CMD_RESEND = 2'd2,
        CMD_NONE   = 2'd3
    } isc_cmd_e;

    // States of the resend walker
    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_APPLY = 2'd1,
        SCAN_HOLD  = 2'd2
    } isc_scan_e;

endpackage

// File: rtl/isc_src_cell.sv
module isc_src_cell #(
    parameter int SRV_W  = 4,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              assign_hit,
    input  logic              assign_level,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              reject_hit,
    input  logic              eoi_hit,
    input  logic              scan_hit,
    input  logic              pop,
    output logic              queued_o,
    output logic [SRV_W-1:0]  server_o,
    output logic [PRIO_W-1:0] prio_o
);

    logic              lvl_q, line_q, sent_q, rej_q, mpend_q, queued_q;
    logic [SRV_W-1:0]  server_q;
    logic [PRIO_W-1:0] prio_q;

    logic              n_lvl, n_sent, n_rej, n_mp, n_q;
    logic [SRV_W-1:0]  n_srv;
    logic [PRIO_W-1:0] n_pr;
    logic              rise;

    assign rise = line_in && !line_q;

    // Ordered application: type, pop, resend, config, command, input edge
    always_comb begin
        n_lvl  = lvl_q;
        n_sent = sent_q;
        n_rej  = rej_q;
        n_mp   = mpend_q;
        n_q    = queued_q;
        n_srv  = server_q;
        n_pr   = prio_q;

        if (assign_hit) n_lvl = assign_level;
        if (pop)        n_q   = 1'b0;

        if (scan_hit) begin
            if (n_lvl) begin
                if (line_q && !n_sent && !(&n_pr)) begin
                    n_sent = 1'b1;
                    n_q    = 1'b1;
                end
            end else if (n_rej) begin
                n_rej = 1'b0;
                if (!(&n_pr)) n_q = 1'b1;
            end
        end

        if (cfg_hit) begin
            n_srv = cfg_server;
            n_pr  = cfg_prio;
            if (n_q && (&cfg_prio)) begin
                n_q = 1'b0;
                if (n_lvl) n_sent = 1'b0;
                else       n_mp   = 1'b1;
            end
            if (n_lvl) begin
                if (line_q && !n_sent && !(&n_pr)) begin
                    n_sent = 1'b1;
                    n_q    = 1'b1;
                end
            end else if (n_mp && !(&n_pr)) begin
                n_mp = 1'b0;
                n_q  = 1'b1;
            end
        end

        if (reject_hit) begin
            n_rej  = 1'b1;
            n_sent = 1'b0;
        end
        if (eoi_hit && n_lvl) n_sent = 1'b0;

        if (rise) begin
            if (n_lvl) begin
                if (!n_sent && !(&n_pr)) begin
                    n_sent = 1'b1;
                    n_q    = 1'b1;
                end
            end else if (&n_pr) begin
                n_mp = 1'b1;
            end else begin
                n_q = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q    <= 1'b0;
            line_q   <= 1'b0;
            sent_q   <= 1'b0;
            rej_q    <= 1'b0;
            mpend_q  <= 1'b0;
            queued_q <= 1'b0;
            server_q <= '0;
            prio_q   <= '1;
        end else begin
            lvl_q    <= n_lvl;
            line_q   <= line_in;
            sent_q   <= n_sent;
            rej_q    <= n_rej;
            mpend_q  <= n_mp;
            queued_q <= n_q;
            server_q <= n_srv;
            prio_q   <= n_pr;
        end
    end

    assign queued_o = queued_q;
    assign server_o = server_q;
    assign prio_o   = prio_q;

    assert_masked_not_owed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        queued_q |-> !(&prio_q));

    assert_reject_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_hit && !(line_in && !line_q)) |=> (rej_q && !sent_q));

    assert_eoi_level_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && lvl_q && !assign_hit && !(line_in && !line_q)) |=> !sent_q);

    assert_eoi_message_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && !lvl_q && !assign_hit && !cfg_hit && !scan_hit && !pop
         && !(line_in && !line_q))
        |=> ($stable(rej_q) && $stable(mpend_q) && $stable(queued_q)));

    assert_level_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q && sent_q && !queued_q && !reject_hit && !eoi_hit && !cfg_hit && !assign_hit)
        |=> !queued_q);

    assert_withdraw_on_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && (&cfg_prio)) |=> !queued_q);

endmodule

// File: rtl/isc_pick_lowest.sv
module isc_pick_lowest #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (any) assert_pick_is_set_R10: assert (req[idx]);
    end

endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan
    import isc_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] queued,
    output logic [N-1:0] scan_hit
);

    isc_scan_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SCAN_IDLE: ;
            SCAN_APPLY: state_d = SCAN_HOLD;
            SCAN_HOLD: begin
                if (!queued[idx_q]) begin
                    if (idx_q == IDX_W'(N - 1)) begin
                        state_d = SCAN_IDLE;
                        idx_d   = '0;
                    end else begin
                        state_d = SCAN_APPLY;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = SCAN_IDLE;
        endcase
        if (start) begin
            state_d = SCAN_APPLY;
            idx_d   = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        scan_hit = '0;
        if (state_q == SCAN_APPLY) scan_hit[idx_q] = 1'b1;
    end

    assert_apply_then_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCAN_APPLY && !start) |=> (state_q == SCAN_HOLD));

    assert_hold_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCAN_HOLD && queued[idx_q] && !start)
        |=> (state_q == SCAN_HOLD && $stable(idx_q)));

endmodule

// File: rtl/isc_mixed_src_ctrl.sv
module isc_mixed_src_ctrl
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_W   = 10,
    parameter int BASE    = 64,
    parameter int SRV_W   = 4,
    parameter int PRIO_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic               asg_valid,
    input  logic [NUM_W-1:0]   asg_num,
    input  logic               asg_level,
    input  logic               cfg_valid,
    input  logic [NUM_W-1:0]   cfg_num,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [NUM_W-1:0]   cmd_num,
    output logic               pres_valid,
    input  logic               pres_ready,
    output logic [SRV_W-1:0]   pres_server,
    output logic [NUM_W-1:0]   pres_num,
    output logic [PRIO_W-1:0]  pres_prio
);

    localparam int IDX_W = $clog2(NUM_SRC);
    localparam logic [NUM_W:0]     LO_NUM   = (NUM_W+1)'(BASE);
    localparam logic [NUM_W:0]     HI_NUM   = (NUM_W+1)'(BASE + NUM_SRC);
    localparam logic [IDX_W-1:0]   BASE_LOW = IDX_W'(BASE);
    localparam logic [NUM_W-1:0]   BASE_N   = NUM_W'(BASE);

    function automatic logic in_window(input logic [NUM_W-1:0] n);
        return ({1'b0, n} >= LO_NUM) && ({1'b0, n} < HI_NUM);
    endfunction

    isc_cmd_e         op;
    logic             asg_ok, cfg_ok, cmd_ok, start_scan;
    logic [IDX_W-1:0] asg_idx, cfg_idx, cmd_idx, sel_idx;

    logic [NUM_SRC-1:0] queued, scan_hit, pop;
    logic [SRV_W-1:0]   server_arr [NUM_SRC];
    logic [PRIO_W-1:0]  prio_arr   [NUM_SRC];

    assign op         = isc_cmd_e'(cmd_op);
    assign asg_ok     = asg_valid && in_window(asg_num);
    assign cfg_ok     = cfg_valid && in_window(cfg_num);
    assign cmd_ok     = cmd_valid && in_window(cmd_num);
    assign asg_idx    = asg_num[IDX_W-1:0] - BASE_LOW;
    assign cfg_idx    = cfg_num[IDX_W-1:0] - BASE_LOW;
    assign cmd_idx    = cmd_num[IDX_W-1:0] - BASE_LOW;
    assign start_scan = cmd_valid && (op == CMD_RESEND);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            logic hit_asg, hit_cfg, hit_rej, hit_eoi;
            assign hit_asg = asg_ok && (asg_idx == IDX_W'(g));
            assign hit_cfg = cfg_ok && (cfg_idx == IDX_W'(g));
            assign hit_rej = cmd_ok && (op == CMD_REJECT) && (cmd_idx == IDX_W'(g));
            assign hit_eoi = cmd_ok && (op == CMD_EOI)    && (cmd_idx == IDX_W'(g));
            assign pop[g]  = pres_valid && pres_ready && (sel_idx == IDX_W'(g));

            isc_src_cell #(
                .SRV_W (SRV_W),
                .PRIO_W(PRIO_W)
            ) cell_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .line_in     (src_line[g]),
                .assign_hit  (hit_asg),
                .assign_level(asg_level),
                .cfg_hit     (hit_cfg),
                .cfg_server  (cfg_server),
                .cfg_prio    (cfg_prio),
                .reject_hit  (hit_rej),
                .eoi_hit     (hit_eoi),
                .scan_hit    (scan_hit[g]),
                .pop         (pop[g]),
                .queued_o    (queued[g]),
                .server_o    (server_arr[g]),
                .prio_o      (prio_arr[g])
            );
        end
    endgenerate

    isc_resend_scan #(.N(NUM_SRC)) scan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_scan),
        .queued  (queued),
        .scan_hit(scan_hit)
    );

    isc_pick_lowest #(.N(NUM_SRC)) pick_i (
        .req(queued),
        .any(pres_valid),
        .idx(sel_idx)
    );

    assign pres_server = server_arr[sel_idx];
    assign pres_prio   = prio_arr[sel_idx];
    assign pres_num    = BASE_N + {{(NUM_W-IDX_W){1'b0}}, sel_idx};

    assert_offer_unmasked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> !(&pres_prio));

    assert_num_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> in_window(pres_num));

    assert_offer_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_valid && !pres_ready && !cfg_valid) |=> pres_valid);

    assert_single_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pop) <= 1);

endmodule

// File: tb/isc_mixed_src_ctrl_tb_top.sv
`timescale 1ns/100ps
module isc_mixed_src_ctrl_tb_top;

    localparam int N    = 16;
    localparam int NW   = 10;
    localparam int BASE = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  lines = '0;
    logic          asg_valid = 1'b0, asg_level = 1'b0;
    logic [NW-1:0] asg_num = '0;
    logic          cfg_valid = 1'b0;
    logic [NW-1:0] cfg_num = '0;
    logic [3:0]    cfg_server = '0;
    logic [7:0]    cfg_prio = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd3;
    logic [NW-1:0] cmd_num = '0;
    logic          pres_valid, pres_ready = 1'b0;
    logic [3:0]    pres_server;
    logic [NW-1:0] pres_num;
    logic [7:0]    pres_prio;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    isc_mixed_src_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_line(lines),
        .asg_valid(asg_valid), .asg_num(asg_num), .asg_level(asg_level),
        .cfg_valid(cfg_valid), .cfg_num(cfg_num), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
        .pres_valid(pres_valid), .pres_ready(pres_ready), .pres_server(pres_server),
        .pres_num(pres_num), .pres_prio(pres_prio)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_tuple(input string tag, input int num, input int srv, input int prio);
        check_eq({tag, " valid"}, int'(pres_valid), 1);
        check_eq({tag, " num"},   int'(pres_num),   num);
        check_eq({tag, " server"}, int'(pres_server), srv);
        check_eq({tag, " prio"},  int'(pres_prio),  prio);
    endtask

    task automatic quiet(input string tag, input int n);
        repeat (n) @(negedge clk);
        check_eq({tag, " idle"}, int'(pres_valid), 0);
    endtask

    task automatic wait_valid(input int n);
        for (int k = 0; k < n && !pres_valid; k++) @(negedge clk);
    endtask

    task automatic pop_one();
        @(negedge clk) pres_ready = 1'b1;
        @(negedge clk) pres_ready = 1'b0;
    endtask

    task automatic drain();
        while (pres_valid) pop_one();
    endtask

    task automatic do_cfg(input int num, input int srv, input int prio);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_num = NW'(num); cfg_server = 4'(srv); cfg_prio = 8'(prio);
        @(negedge clk) cfg_valid = 1'b0;
    endtask

    task automatic do_asg(input int num, input logic lvl);
        @(negedge clk);
        asg_valid = 1'b1; asg_num = NW'(num); asg_level = lvl;
        @(negedge clk) asg_valid = 1'b0;
    endtask

    task automatic do_cmd(input int op, input int num);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_num = NW'(num);
        @(negedge clk) cmd_valid = 1'b0;
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk) lines[i] = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R3 reset no offer", int'(pres_valid), 0);

        // R3/R1: reset priority masks source 0; edge only marks pending
        set_line(0, 1'b1);
        quiet("R3 masked at reset", 2);
        do_cfg(BASE + 0, 3, 5);
        expect_tuple("R9 pending shown on unmask", BASE + 0, 3, 5);
        pop_one();
        check_eq("R10 taken", int'(pres_valid), 0);
        set_line(0, 1'b0);

        // R2: out-of-window numbers, one aliasing index 1
        set_line(1, 1'b1);
        do_cfg(BASE + N + 1, 2, 7);
        do_cfg(BASE - 1, 2, 7);
        quiet("R2 out of window", 3);
        do_cfg(BASE + 1, 2, 7);
        expect_tuple("R2 in window", BASE + 1, 2, 7);
        pop_one();
        set_line(1, 1'b0);

        // R13/R5/R7/R8: level source 2
        do_asg(BASE + N + 2, 1'b1);   // ignored, out of window
        do_asg(BASE + 2, 1'b1);
        do_cfg(BASE + 2, 1, 9);
        quiet("R5 not asserted", 2);
        set_line(2, 1'b1);
        expect_tuple("R13 R5 level rise", BASE + 2, 1, 9);
        pop_one();
        quiet("R5 no repeat while sent", 4);
        do_cmd(2, 0);
        quiet("R8 level sent blocks", 50);
        do_cmd(1, BASE + 2);
        quiet("R7 eoi presents nothing", 4);
        do_cmd(2, 0);
        wait_valid(100);
        expect_tuple("R8 level after eoi", BASE + 2, 1, 9);
        pop_one();
        do_cmd(0, BASE + 2);
        quiet("R6 reject silent", 5);
        do_cmd(2, 0);
        wait_valid(100);
        expect_tuple("R6 level after reject", BASE + 2, 1, 9);
        pop_one();

        // R4/R6/R8/R7: message source 3
        do_cfg(BASE + 3, 0, 4);
        quiet("R4 no edge", 2);
        set_line(3, 1'b1);
        expect_tuple("R4 message edge", BASE + 3, 0, 4);
        pop_one();
        set_line(3, 1'b0);
        do_cmd(0, BASE + 3);
        quiet("R6 message reject silent", 3);
        do_cmd(2, 0);
        wait_valid(100);
        expect_tuple("R8 message resend", BASE + 3, 0, 4);
        pop_one();
        do_cmd(2, 0);
        quiet("R8 rejected cleared", 50);
        do_cmd(1, BASE + 3);
        do_cmd(2, 0);
        quiet("R7 message eoi inert", 50);

        // R10: ordering and stall
        do_cfg(BASE + 5, 5, 1);
        do_cfg(BASE + 9, 9, 2);
        do_cfg(BASE + 12, 12, 3);
        @(negedge clk) begin lines[12] = 1'b1; lines[9] = 1'b1; lines[5] = 1'b1; end
        @(negedge clk);
        expect_tuple("R10 lowest first", BASE + 5, 5, 1);
        pop_one();
        check_eq("R10 next", int'(pres_num), BASE + 9);
        pop_one();
        check_eq("R10 last", int'(pres_num), BASE + 12);
        pop_one();
        do_cmd(0, BASE + 12);
        do_cmd(0, BASE + 5);
        do_cmd(0, BASE + 9);
        do_cmd(2, 0);
        wait_valid(100);
        expect_tuple("R10 scan first", BASE + 5, 5, 1);
        repeat (10) @(negedge clk);
        check_eq("R10 stall holds", int'(pres_num), BASE + 5);
        pop_one();
        wait_valid(100);
        expect_tuple("R10 scan second", BASE + 9, 9, 2);
        pop_one();
        wait_valid(100);
        expect_tuple("R10 scan third", BASE + 12, 12, 3);
        pop_one();
        quiet("R10 scan done", 40);

        // R12: command before input in the same cycle
        do_asg(BASE + 6, 1'b1);
        do_cfg(BASE + 6, 6, 6);
        set_line(6, 1'b1);
        expect_tuple("R12 setup", BASE + 6, 6, 6);
        pop_one();
        set_line(6, 1'b0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_num = NW'(BASE + 6); lines[6] = 1'b1;
        @(negedge clk) cmd_valid = 1'b0;
        expect_tuple("R12 reject then edge", BASE + 6, 6, 6);
        pop_one();

        // R11: mask withdraws an owed offer
        do_cfg(BASE + 7, 7, 3);
        set_line(7, 1'b1);
        check_eq("R11 owed", int'(pres_num), BASE + 7);
        do_cfg(BASE + 7, 7, 255);
        check_eq("R11 withdrawn", int'(pres_valid), 0);
        do_cfg(BASE + 7, 7, 3);
        expect_tuple("R11 back as pending", BASE + 7, 7, 3);
        pop_one();

        // Sweep over every source, message type
        @(negedge clk) lines = '0;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            do_asg(BASE + i, 1'b0);
            do_cfg(BASE + i, (i * 5) % 16, (i * 17 + 1) % 256);
            drain();
            set_line(i, 1'b1);
            expect_tuple("R4 R2 sweep", BASE + i, (i * 5) % 16, (i * 17 + 1) % 256);
            pop_one();
            set_line(i, 1'b0);
            do_cfg(BASE + i, 0, 255);
            set_line(i, 1'b1);
            check_eq("R1 sweep masked", int'(pres_valid), 0);
            do_cfg(BASE + i, (i * 3) % 16, i + 1);
            expect_tuple("R9 sweep unmask", BASE + i, (i * 3) % 16, i + 1);
            pop_one();
            set_line(i, 1'b0);
        end

        finish_run();
    end

endmodule